// File: doc/BRIEF.md
# Memory Protection Control and Access Gate

This block holds the single control word of a memory protection unit and turns every memory access into a verdict. A verdict says whether the access is allowed, whether it raises a memory-management fault, and whether the access uses the default memory map. The block also says whether the execute-never and strongly-ordered attributes are forced onto the access. An external region matcher reports whether the access hit an enabled region and whether that region's permissions allow the access. This block adds the global rules on top of that answer: the master enable, a background map that only privileged code may use, a bypass for the escalated fault handlers, and the system areas that are always reachable.

Software reaches the control word through a small word-wide register port at offset 0x04. Only privileged writes change it. The access-check path is combinational from the access inputs and the stored control word, so a write changes the verdicts of accesses checked from the next clock cycle onward.

Top module: `memprot_gate`

## Requirements
- R1: Synchronous active-high reset clears the control word to zero. After reset, a read at offset 0x04 returns 0 and every access is allowed with the default map.
- R2: A privileged write at offset 0x04 stores write-data bits [2:0]: bit 0 is the master enable, bit 1 the escalated-handler enable, bit 2 the privileged background enable. Reads at 0x04 return the word one cycle later with bits [31:3] zero. Reads at any other offset return 0, and writes to any other offset change nothing.
- R3: An unprivileged write at offset 0x04 leaves the control word unchanged. In the cycle after that write, reg_err is 1 for exactly one cycle. reg_err is 0 at all other times.
- R4: When the protection is not in effect, every access has allow=1, default_map=1 and fault=0.
- R5: When protection is in effect and the access is in the "other" class with acc_region_hit=1, allow equals acc_region_ok, fault is its inverse, and default_map=0.
- R6: When protection is in effect and the background enable is set, a privileged "other" access with no region hit is allowed with default_map=1 and fault=0.
- R7: When protection is in effect, an unprivileged "other" access with no region hit faults, whatever the background enable is. A privileged miss also faults when the background enable is clear. A faulting access has allow=0 and default_map=0.
- R8: The class codes are 2'b00 other, 2'b01 system control space, 2'b10 vector table, and 2'b11 treated as other. When protection is in effect, system control space and vector table accesses are always allowed with default_map=1, whatever the region inputs are.
- R9: Protection is in effect when the master enable is set, except when acc_prio is -1 or -2 (two's complement) and the escalated-handler enable is clear. In that case the unit behaves as disabled. Other negative priorities get no bypass.
- R10: acc_force_xn and acc_force_so are 1 exactly for system control space accesses, whatever the control word is.
- R11: A control-word write changes the verdict starting in the cycle after the clock edge that takes the write, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_priv | input | 1 | Register access is privileged |
| reg_rdata | output | DATA_W | Registered read data |
| reg_err | output | 1 | One-cycle pulse after a refused write |
| acc_class | input | 2 | Address class of the checked access |
| acc_priv | input | 1 | Checked access is privileged |
| acc_prio | input | PRIO_W | Current execution priority, signed |
| acc_region_hit | input | 1 | External matcher found an enabled region |
| acc_region_ok | input | 1 | Matched region permits the access |
| acc_allow | output | 1 | Access is permitted |
| acc_fault | output | 1 | Memory-management fault |
| acc_default_map | output | 1 | Access follows the default memory map |
| acc_force_xn | output | 1 | Execute-never forced |
| acc_force_so | output | 1 | Strongly-ordered forced |

## Verification
Almost all state lives in the three control bits, so a wrong bit shows up in the very next combinational verdict. For example, a lost master enable makes unprivileged misses come back allowed instead of faulting. A flipped background bit changes privileged misses between default-map and fault. A stuck escalated-handler bit changes only accesses at priority -1 or -2, so the bench repeats those priorities with both settings of that bit. A register-port fault, such as an unprivileged write that gets through or a missing error pulse, shows on reg_rdata one cycle after a read and on reg_err one cycle after the write.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

  typedef enum logic [1:0] {
    AC_OTHER = 2'b00,
    AC_SCS   = 2'b01,
    AC_VTAB  = 2'b10,
    AC_RSVD  = 2'b11
  } acc_class_e;

  localparam int CTL_BITS = 3;
  localparam int BIT_ON   = 0;
  localparam int BIT_HF   = 1;
  localparam int BIT_BG   = 2;

  typedef struct packed {
    logic allow;
    logic fault;
    logic dflt;
    logic xn;
    logic so;
  } verdict_t;

endpackage

// File: rtl/memprot_ctl_reg.sv
module memprot_ctl_reg
  import memprot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CTL_OFS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                rd,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                priv,
  output logic [CTL_BITS-1:0] ctl,
  output logic [DATA_W-1:0]   rdata,
  output logic                err
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTL_OFS);

  logic hit;
  logic unused_hi;

  assign hit       = (addr == OFS);
  assign unused_hi = ^wdata[DATA_W-1:CTL_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      if (wr && hit) begin
        if (priv) ctl <= wdata[CTL_BITS-1:0];
        else      err <= 1'b1;
      end
      if (rd && hit) rdata <= {{(DATA_W-CTL_BITS){1'b0}}, ctl};
      else           rdata <= '0;
    end
  end

endmodule

// File: rtl/memprot_esc_detect.sv
module memprot_esc_detect #(
  parameter int PRIO_W = 9
) (
  input  logic [PRIO_W-1:0] prio,
  output logic              escalated
);

  localparam logic [PRIO_W-1:0] MINUS_ONE = '1;
  localparam logic [PRIO_W-1:0] MINUS_TWO = MINUS_ONE - PRIO_W'(1);

  assign escalated = (prio == MINUS_ONE) || (prio == MINUS_TWO);

endmodule

// File: rtl/memprot_decide.sv
module memprot_decide
  import memprot_pkg::*;
(
  input  logic [CTL_BITS-1:0] ctl,
  input  logic                escalated,
  input  logic [1:0]          cls,
  input  logic                priv,
  input  logic                hit,
  input  logic                ok,
  output verdict_t            v
);

  logic active;
  logic sys_area;
  logic is_scs;

  assign active   = ctl[BIT_ON] && !(escalated && !ctl[BIT_HF]);
  assign is_scs   = (cls == AC_SCS);
  assign sys_area = is_scs || (cls == AC_VTAB);

  always_comb begin
    v.xn = is_scs;
    v.so = is_scs;
    if (!active || sys_area) begin
      v.allow = 1'b1;
      v.fault = 1'b0;
      v.dflt  = 1'b1;
    end else if (hit) begin
      v.allow = ok;
      v.fault = !ok;
      v.dflt  = 1'b0;
    end else if (priv && ctl[BIT_BG]) begin
      v.allow = 1'b1;
      v.fault = 1'b0;
      v.dflt  = 1'b1;
    end else begin
      v.allow = 1'b0;
      v.fault = 1'b1;
      v.dflt  = 1'b0;
    end
  end

endmodule

// File: rtl/memprot_gate.sv
module memprot_gate
  import memprot_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CTL_OFS = 4,
  parameter int PRIO_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_priv,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_err,
  input  logic [1:0]        acc_class,
  input  logic              acc_priv,
  input  logic [PRIO_W-1:0] acc_prio,
  input  logic              acc_region_hit,
  input  logic              acc_region_ok,
  output logic              acc_allow,
  output logic              acc_fault,
  output logic              acc_default_map,
  output logic              acc_force_xn,
  output logic              acc_force_so
);

  logic [CTL_BITS-1:0] ctl_q;
  logic                escalated;
  verdict_t            verdict;

  memprot_ctl_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_OFS(CTL_OFS)
  ) i_ctl_reg (
    .clk  (clk),
    .rst  (rst),
    .wr   (reg_wr),
    .rd   (reg_rd),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .priv (reg_priv),
    .ctl  (ctl_q),
    .rdata(reg_rdata),
    .err  (reg_err)
  );

  memprot_esc_detect #(.PRIO_W(PRIO_W)) i_esc (
    .prio     (acc_prio),
    .escalated(escalated)
  );

  memprot_decide i_decide (
    .ctl      (ctl_q),
    .escalated(escalated),
    .cls      (acc_class),
    .priv     (acc_priv),
    .hit      (acc_region_hit),
    .ok       (acc_region_ok),
    .v        (verdict)
  );

  assign acc_allow       = verdict.allow;
  assign acc_fault       = verdict.fault;
  assign acc_default_map = verdict.dflt;
  assign acc_force_xn    = verdict.xn;
  assign acc_force_so    = verdict.so;

endmodule

// File: rtl/memprot_gate_chk.sv
module memprot_gate_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CTL_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_priv,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_err,
  input logic [1:0]        acc_class,
  input logic              acc_allow,
  input logic              acc_fault,
  input logic              acc_default_map,
  input logic              acc_force_xn,
  input logic              acc_force_so,
  input logic [2:0]        ctl_q
);

  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTL_OFS);

  logic at_ofs;
  assign at_ofs = (reg_addr == OFS);

  // R1
  rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctl_q == 3'b000);

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_priv && at_ofs) |=> ctl_q == $past(reg_wdata[2:0]));

  // R2
  rdata_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && at_ofs) |=> reg_rdata == {{(DATA_W-3){1'b0}}, $past(ctl_q)});

  // R3
  unpriv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_priv && at_ofs) |=> ($stable(ctl_q) && reg_err));

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    reg_err |-> $past(reg_wr && !reg_priv && at_ofs));

  // R4
  off_default_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[0] |-> (acc_allow && acc_default_map && !acc_fault));

  // R7
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    acc_fault |-> (!acc_allow && !acc_default_map));

  // R8
  sys_allow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_class == 2'b01 || acc_class == 2'b10) |-> acc_allow);

  // R10
  scs_attr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_class == 2'b01) == (acc_force_xn && acc_force_so));

endmodule

bind memprot_gate memprot_gate_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CTL_OFS(CTL_OFS)
) i_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .reg_priv       (reg_priv),
  .reg_rdata      (reg_rdata),
  .reg_err        (reg_err),
  .acc_class      (acc_class),
  .acc_allow      (acc_allow),
  .acc_fault      (acc_fault),
  .acc_default_map(acc_default_map),
  .acc_force_xn   (acc_force_xn),
  .acc_force_so   (acc_force_so),
  .ctl_q          (ctl_q)
);

// File: tb/test_memprot_gate.sv
module test_memprot_gate;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 9;

  localparam logic [1:0] C_OTH = 2'b00;
  localparam logic [1:0] C_SCS = 2'b01;
  localparam logic [1:0] C_VT  = 2'b10;
  localparam logic [1:0] C_RSV = 2'b11;

  localparam logic [PRIO_W-1:0] P_NORM = 9'd5;
  localparam logic [PRIO_W-1:0] P_M1   = 9'h1FF;
  localparam logic [PRIO_W-1:0] P_M2   = 9'h1FE;
  localparam logic [PRIO_W-1:0] P_M3   = 9'h1FD;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic              reg_priv = 1'b0;
  logic [DATA_W-1:0] reg_rdata;
  logic              reg_err;
  logic [1:0]        acc_class = C_OTH;
  logic              acc_priv = 1'b0;
  logic [PRIO_W-1:0] acc_prio = P_NORM;
  logic              acc_region_hit = 1'b0;
  logic              acc_region_ok = 1'b0;
  logic              acc_allow;
  logic              acc_fault;
  logic              acc_default_map;
  logic              acc_force_xn;
  logic              acc_force_so;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  memprot_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_OFS(4), .PRIO_W(PRIO_W)) i_memprot_gate (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_priv(reg_priv), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .acc_class(acc_class), .acc_priv(acc_priv), .acc_prio(acc_prio),
    .acc_region_hit(acc_region_hit), .acc_region_ok(acc_region_ok),
    .acc_allow(acc_allow), .acc_fault(acc_fault), .acc_default_map(acc_default_map),
    .acc_force_xn(acc_force_xn), .acc_force_so(acc_force_so)
  );

  task automatic check_val(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic p);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_priv = p;
    @(negedge clk);
    reg_wr = 1'b0; reg_priv = 1'b0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // expected allow, fault, default; xn/so derive from class per R10
  task automatic check_acc(string req, logic [1:0] c, logic p, logic [PRIO_W-1:0] pr,
                           logic h, logic ok, logic e_allow, logic e_fault, logic e_dflt);
    @(negedge clk);
    acc_class = c; acc_priv = p; acc_prio = pr; acc_region_hit = h; acc_region_ok = ok;
    #1;
    check_val({req, " allow"},   DATA_W'(acc_allow), DATA_W'(e_allow));
    check_val({req, " fault"},   DATA_W'(acc_fault), DATA_W'(e_fault));
    check_val({req, " default"}, DATA_W'(acc_default_map), DATA_W'(e_dflt));
    check_val("R10 xn", DATA_W'(acc_force_xn), DATA_W'(c == C_SCS));
    check_val("R10 so", DATA_W'(acc_force_so), DATA_W'(c == C_SCS));
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    do_read(8'h04, d);
    check_val("R1 ctl after reset", d, 0);
    check_acc("R1", C_OTH, 1'b0, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_val("R3 err idle", DATA_W'(reg_err), 0);
  endtask

  task automatic t_regport();
    logic [DATA_W-1:0] d;
    do_write(8'h04, 32'hFFFF_FFF8, 1'b1);
    do_read(8'h04, d);
    check_val("R2 upper bits dropped", d, 0);
    do_write(8'h04, 32'hFFFF_FFFF, 1'b1);
    do_read(8'h04, d);
    check_val("R2 readback", d, 32'd7);
    do_read(8'h08, d);
    check_val("R2 other offset read", d, 0);
    do_write(8'h08, 32'h0, 1'b1);
    do_read(8'h04, d);
    check_val("R2 other offset write ignored", d, 32'd7);
    do_write(8'h04, 32'h5, 1'b1);
    do_read(8'h04, d);
    check_val("R2 readback 5", d, 32'd5);
  endtask

  task automatic t_unpriv_write();
    logic [DATA_W-1:0] d;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h0; reg_priv = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
    check_val("R3 err pulse", DATA_W'(reg_err), 1);
    @(negedge clk);
    check_val("R3 err one cycle", DATA_W'(reg_err), 0);
    do_read(8'h04, d);
    check_val("R3 ctl unchanged", d, 32'd5);
  endtask

  task automatic t_disabled();
    do_write(8'h04, 32'h6, 1'b1);
    check_acc("R4 unpriv miss", C_OTH, 1'b0, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R4 hit denied", C_OTH, 1'b0, P_NORM, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_region_hit();
    do_write(8'h04, 32'h1, 1'b1);
    check_acc("R5 hit ok", C_OTH, 1'b0, P_NORM, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check_acc("R5 hit deny", C_OTH, 1'b1, P_NORM, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check_acc("R5 reserved class hit", C_RSV, 1'b0, P_NORM, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_background();
    do_write(8'h04, 32'h5, 1'b1);
    check_acc("R6 priv miss bg", C_OTH, 1'b1, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R7 unpriv miss bg", C_OTH, 1'b0, P_NORM, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_miss_fault();
    do_write(8'h04, 32'h1, 1'b1);
    check_acc("R7 priv miss nobg", C_OTH, 1'b1, P_NORM, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_acc("R7 unpriv miss nobg", C_OTH, 1'b0, P_NORM, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_system_areas();
    do_write(8'h04, 32'h1, 1'b1);
    check_acc("R8 scs miss", C_SCS, 1'b0, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R8 vt denied hit", C_VT, 1'b0, P_NORM, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_escalation();
    do_write(8'h04, 32'h1, 1'b1);
    check_acc("R9 prio -1 bypass", C_OTH, 1'b0, P_M1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R9 prio -2 bypass", C_OTH, 1'b0, P_M2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R9 prio -3 no bypass", C_OTH, 1'b0, P_M3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    do_write(8'h04, 32'h3, 1'b1);
    check_acc("R9 prio -1 hf set", C_OTH, 1'b0, P_M1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_acc("R9 prio -2 hf set hit", C_OTH, 1'b0, P_M2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_attrs();
    do_write(8'h04, 32'h0, 1'b1);
    check_acc("R10 scs while off", C_SCS, 1'b1, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    check_acc("R10 vt while off", C_VT, 1'b1, P_NORM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_timing();
    @(negedge clk);
    acc_class = C_OTH; acc_priv = 1'b0; acc_prio = P_NORM;
    acc_region_hit = 1'b0; acc_region_ok = 1'b0;
    reg_wr = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h1; reg_priv = 1'b1;
    #1;
    check_val("R11 before edge allow", DATA_W'(acc_allow), 1);
    @(posedge clk);
    #1;
    check_val("R11 after edge fault", DATA_W'(acc_fault), 1);
    @(negedge clk);
    reg_wr = 1'b0; reg_priv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regport();
    t_unpriv_write();
    t_disabled();
    t_region_hit();
    t_background();
    t_miss_fault();
    t_system_areas();
    t_escalation();
    t_attrs();
    t_timing();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule